// File: doc/BRIEF.md
# Two-Level Event Interrupt Aggregator

This block gathers the request pulses of a timer event array (seventeen capture/compare channels, eight output channels, four timer wrap events and seventeen per-channel capture overruns) and reduces them to a handful of request lines for an interrupt controller. Thirty-two of these sources latch into two sixteen-bit groups. Each group has its own pending and mask registers and yields one summary request. A routing byte then steers each summary to either a normal interrupt output or a transfer-server output. The overruns of channels 3 to 16 are merged into one shared request, which has its own pending bit and mask bit.

Software reaches every register through a small synchronous register bus: a 3-bit address, 16-bit write data, a write strobe and combinational read data. A pending bit latches whether or not it is masked, so software can poll for events. Writing ones to a pending register clears those bits. Vectoring, priority arbitration and the CPU side sit outside this block.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A pulse on capture channel i (i = 0..15) sets bit i of the group-0 pending register (address 0) on the next clock edge.
- R2: The group-1 pending register (address 2) is laid out as follows. Bit 15 is capture channel 16. Bits 14..7 are output channels 7..0, with output channel j at bit 7+j. Bits 6..3 are timer wrap events 1..4, with timer k at bit 7-k. Bits 2..0 are the overruns of capture channels 0..2, with overrun of channel c at bit 2-c.
- R3: An overrun on any capture channel from 3 to 16 sets bit 0 of the shared pending register (address 4). Overruns of channels 0 to 2 leave that bit unchanged.
- R4: A pending bit is set by its event even when the matching mask bit is clear. A pending bit holds until software clears it.
- R5: Writing to a pending register clears every bit written as 1 and leaves every bit written as 0 unchanged. A hardware set in the same cycle as a clear wins, so the bit stays 1.
- R6: The group g summary is the OR over its 16 bits of (pending AND mask). The masks sit at address 1 (group 0) and address 3 (group 1). The routing byte (address 6) holds the enables: bit 0 is the group-0 interrupt enable, bit 1 the group-0 transfer enable, bit 2 the group-1 interrupt enable and bit 3 the group-1 transfer enable. int_req[g] is 1 only when the summary is 1 and the interrupt enable is 1. xfer_req[g] is 1 only when the summary is 1 and the transfer enable is 1.
- R7: When both enables of a group are set, only xfer_req[g] is driven high and int_req[g] stays low.
- R8: ovr_req is 1 exactly when bit 0 of the shared pending register and bit 0 of the shared mask register (address 5) are both 1.
- R9: After reset, all pending registers, all mask registers and the routing byte read 0, and all request outputs are low.
- R10: Bits 7..4 of the routing byte, which include the placeholder positions for the non-maskable and stack-overflow enables at bits 6 and 7, are stored and read back as written. They have no effect on any output.
- R11: Writing a mask register changes neither pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_cap | input | 17 | Capture/compare channel event pulses, channels 0..16 |
| ev_out | input | 8 | Output channel event pulses, channels 0..7 |
| ev_tmr | input | 4 | Timer wrap pulses, index 0 is timer 1 |
| ev_ovr | input | 17 | Capture overrun pulses, channels 0..16 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for bus_addr, unused addresses read 0 |
| int_req | output | 2 | Normal interrupt request per group |
| xfer_req | output | 2 | Transfer-server request per group |
| ovr_req | output | 1 | Shared overrun request |

## Verification
Some properties are checked on every cycle. A set pending bit stays set. A write-one clear removes only the bits that no event is setting. The two outputs of one group are never high together. An interrupt output is only ever high with its enable set. Any overrun on channels 3 to 16 reaches the shared pending bit. The bench scenarios show the rest: the exact bit placement of both groups, that overruns of channels 0 to 2 stay out of the shared bit, polling of masked events, the routing choices, and that the spare routing bits and mask writes have no side effects.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int GRP_W    = 16;
    localparam int NUM_GRP  = 2;
    localparam int NUM_CAP  = 17;
    localparam int NUM_OUT  = 8;
    localparam int NUM_TMR  = 4;
    localparam int NUM_DOVR = 3;   // overruns kept as individual group-1 bits
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 16;
    localparam int ROUTE_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_G0_PEND = 3'd0,
        A_G0_MASK = 3'd1,
        A_G1_PEND = 3'd2,
        A_G1_MASK = 3'd3,
        A_SH_PEND = 3'd4,
        A_SH_MASK = 3'd5,
        A_ROUTE   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       stack_pos;   // placeholder, no effect
        logic       nmi_pos;     // placeholder, no effect
        logic [1:0] spare;
        logic       g1_xfer;
        logic       g1_int;
        logic       g0_xfer;
        logic       g0_int;
    } route_t;

    // Group-1 bit placement: decoded by software, so positions are fixed.
    function automatic logic [GRP_W-1:0] pack_grp1(
        input logic                cap_hi,
        input logic [NUM_OUT-1:0]  outs,
        input logic [NUM_TMR-1:0]  tmrs,
        input logic [NUM_DOVR-1:0] ovrs);
        logic [GRP_W-1:0] v;
        v = '0;
        v[GRP_W-1] = cap_hi;
        for (int j = 0; j < NUM_OUT; j++)  v[NUM_TMR+NUM_DOVR+j] = outs[j];
        for (int k = 0; k < NUM_TMR; k++)  v[NUM_TMR+NUM_DOVR-1-k] = tmrs[k];
        for (int c = 0; c < NUM_DOVR; c++) v[NUM_DOVR-1-c] = ovrs[c];
        return v;
    endfunction
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_wd,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic         req_o
);
    logic [W-1:0] pend_q, mask_q, clr_v;

    always_comb clr_v = clr_we ? clr_wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            if (mask_we) mask_q <= mask_wd;
            pend_q <= (pend_q & ~clr_v) | set_i;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign req_o  = |(pend_q & mask_q);

    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_we) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_we && set_i == '0) |=> ((pend_o & $past(clr_wd)) == '0));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_o == '0 && mask_o == '0));
endmodule

// File: rtl/evt_grp_router.sv
module evt_grp_router (
    input  logic clk,
    input  logic rst,
    input  logic sum_i,
    input  logic int_en,
    input  logic xfer_en,
    output logic int_o,
    output logic xfer_o
);
    assign xfer_o = sum_i & xfer_en;
    assign int_o  = sum_i & int_en & ~xfer_en;

    assert_one_path_R7: assert property (@(posedge clk) disable iff (rst)
        !(int_o && xfer_o));

    assert_int_gate_R6: assert property (@(posedge clk) disable iff (rst)
        int_o |-> (int_en && sum_i));

    assert_xfer_gate_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_o |-> (xfer_en && sum_i));
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
    import evt_irq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [evt_irq_pkg::NUM_CAP-1:0] ev_cap,
    input  logic [evt_irq_pkg::NUM_OUT-1:0] ev_out,
    input  logic [evt_irq_pkg::NUM_TMR-1:0] ev_tmr,
    input  logic [evt_irq_pkg::NUM_CAP-1:0] ev_ovr,
    input  logic [evt_irq_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [evt_irq_pkg::DATA_W-1:0]  bus_wdata,
    input  logic                          bus_we,
    output logic [evt_irq_pkg::DATA_W-1:0]  bus_rdata,
    output logic [evt_irq_pkg::NUM_GRP-1:0] int_req,
    output logic [evt_irq_pkg::NUM_GRP-1:0] xfer_req,
    output logic                          ovr_req
);
    logic [GRP_W-1:0] grp_set  [NUM_GRP];
    logic [GRP_W-1:0] grp_pend [NUM_GRP];
    logic [GRP_W-1:0] grp_mask [NUM_GRP];
    logic [NUM_GRP-1:0] grp_sum;
    logic [NUM_GRP-1:0] en_int, en_xfer;
    logic sh_set, sh_pend, sh_mask;
    route_t route_q;

    always_comb begin
        grp_set[0] = ev_cap[GRP_W-1:0];
        grp_set[1] = pack_grp1(ev_cap[NUM_CAP-1], ev_out, ev_tmr,
                               ev_ovr[NUM_DOVR-1:0]);
    end

    assign sh_set = |ev_ovr[NUM_CAP-1:NUM_DOVR];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(2 * g + 1);
        evt_pend_bank #(.W(GRP_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_i   (grp_set[g]),
            .clr_we  (bus_we && bus_addr == PEND_A),
            .clr_wd  (bus_wdata),
            .mask_we (bus_we && bus_addr == MASK_A),
            .mask_wd (bus_wdata),
            .pend_o  (grp_pend[g]),
            .mask_o  (grp_mask[g]),
            .req_o   (grp_sum[g])
        );
        evt_grp_router u_route (
            .clk     (clk),
            .rst     (rst),
            .sum_i   (grp_sum[g]),
            .int_en  (en_int[g]),
            .xfer_en (en_xfer[g]),
            .int_o   (int_req[g]),
            .xfer_o  (xfer_req[g])
        );
    end

    assign en_int  = {route_q.g1_int,  route_q.g0_int};
    assign en_xfer = {route_q.g1_xfer, route_q.g0_xfer};

    evt_pend_bank #(.W(1)) u_shared (
        .clk     (clk),
        .rst     (rst),
        .set_i   (sh_set),
        .clr_we  (bus_we && bus_addr == A_SH_PEND),
        .clr_wd  (bus_wdata[0]),
        .mask_we (bus_we && bus_addr == A_SH_MASK),
        .mask_wd (bus_wdata[0]),
        .pend_o  (sh_pend),
        .mask_o  (sh_mask),
        .req_o   (ovr_req)
    );

    always_ff @(posedge clk) begin
        if (rst)                               route_q <= '0;
        else if (bus_we && bus_addr == A_ROUTE) route_q <= route_t'(bus_wdata[ROUTE_W-1:0]);
    end

    always_comb begin
        case (bus_addr)
            A_G0_PEND: bus_rdata = grp_pend[0];
            A_G0_MASK: bus_rdata = grp_mask[0];
            A_G1_PEND: bus_rdata = grp_pend[1];
            A_G1_MASK: bus_rdata = grp_mask[1];
            A_SH_PEND: bus_rdata = {{(DATA_W-1){1'b0}}, sh_pend};
            A_SH_MASK: bus_rdata = {{(DATA_W-1){1'b0}}, sh_mask};
            A_ROUTE:   bus_rdata = {{(DATA_W-ROUTE_W){1'b0}}, route_q};
            default:   bus_rdata = '0;
        endcase
    end

    assert_shared_or_R3: assert property (@(posedge clk) disable iff (rst)
        (|ev_ovr[NUM_CAP-1:NUM_DOVR]) |=> sh_pend);

    assert_ovr_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ovr_req |-> sh_mask);

    assert_idle_out_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_req == '0 && xfer_req == '0 && !ovr_req));
endmodule

// File: tb/evt_irq_aggregator_tb.sv
module evt_irq_aggregator_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic [16:0] ev_cap = '0;
    logic [7:0]  ev_out = '0;
    logic [3:0]  ev_tmr = '0;
    logic [16:0] ev_ovr = '0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 0;
    logic [15:0] bus_rdata;
    logic [1:0]  int_req, xfer_req;
    logic        ovr_req;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_irq_aggregator u_dut (
        .clk(clk), .rst(rst), .ev_cap(ev_cap), .ev_out(ev_out), .ev_tmr(ev_tmr),
        .ev_ovr(ev_ovr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .int_req(int_req), .xfer_req(xfer_req), .ovr_req(ovr_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fire(input logic [16:0] c, input logic [7:0] o,
                        input logic [3:0] t, input logic [16:0] v);
        @(negedge clk);
        ev_cap = c; ev_out = o; ev_tmr = t; ev_ovr = v;
        @(negedge clk);
        ev_cap = '0; ev_out = '0; ev_tmr = '0; ev_ovr = '0;
    endtask

    task automatic clean();
        wr(3'd1, 16'h0); wr(3'd3, 16'h0); wr(3'd5, 16'h0); wr(3'd6, 16'h0);
        wr(3'd0, 16'hFFFF); wr(3'd2, 16'hFFFF); wr(3'd4, 16'hFFFF);
    endtask

    // Expected group-1 word, built from the layout in R2.
    function automatic logic [15:0] exp_g1(input logic c16, input logic [7:0] o,
                                           input logic [3:0] t, input logic [2:0] v);
        logic [15:0] e;
        e = '0;
        e[15] = c16;
        for (int j = 0; j < 8; j++) e[7 + j] = o[j];
        for (int k = 1; k <= 4; k++) e[7 - k] = t[k - 1];
        for (int c = 0; c < 3; c++) e[2 - c] = v[c];
        return e;
    endfunction

    task automatic t_reset();
        logic [15:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R9 reg after reset", d, 16'h0);
        end
        chk("R9 outputs after reset", {11'b0, int_req, xfer_req, ovr_req}, 16'h0);
    endtask

    task automatic t_grp0();
        logic [15:0] d;
        clean();
        fire(17'h0A5A3, 8'h0, 4'h0, 17'h0);
        rd(3'd0, d); chk("R1 group0 pattern A", d, 16'hA5A3);
        rd(3'd2, d); chk("R2 group1 untouched by ch0-15", d, 16'h0);
        clean();
        fire(17'h10000, 8'h0, 4'h0, 17'h0);
        rd(3'd0, d); chk("R1 ch16 not in group0", d, 16'h0);
        rd(3'd2, d); chk("R2 ch16 at bit15", d, 16'h8000);
    endtask

    task automatic t_grp1();
        logic [15:0] d;
        clean();
        fire(17'h0, 8'h81, 4'b0001, 17'h00001);
        rd(3'd2, d); chk("R2 out7/out0/tmr1/ovr0", d, exp_g1(1'b0, 8'h81, 4'b0001, 3'b001));
        rd(3'd4, d); chk("R3 ovr0 not shared", d, 16'h0);
        clean();
        fire(17'h0, 8'h3C, 4'b1000, 17'h00004);
        rd(3'd2, d); chk("R2 out5..2/tmr4/ovr2", d, exp_g1(1'b0, 8'h3C, 4'b1000, 3'b100));
        rd(3'd4, d); chk("R3 ovr2 not shared", d, 16'h0);
    endtask

    task automatic t_shared();
        logic [15:0] d;
        clean();
        fire(17'h0, 8'h0, 4'h0, 17'h00008);
        rd(3'd4, d); chk("R3 ovr3 sets shared", d, 16'h1);
        rd(3'd2, d); chk("R3 ovr3 not in group1", d, 16'h0);
        chk("R8 masked shared low", {15'b0, ovr_req}, 16'h0);
        wr(3'd5, 16'h1);
        chk("R8 shared req high", {15'b0, ovr_req}, 16'h1);
        wr(3'd4, 16'h1);
        chk("R8 shared req after clear", {15'b0, ovr_req}, 16'h0);
        fire(17'h0, 8'h0, 4'h0, 17'h10000);
        rd(3'd4, d); chk("R3 ovr16 sets shared", d, 16'h1);
    endtask

    task automatic t_poll();
        logic [15:0] d;
        clean();
        wr(3'd6, 16'h000F);
        fire(17'h00020, 8'h0, 4'h0, 17'h0);
        rd(3'd0, d); chk("R4 masked event latched", d, 16'h0020);
        chk("R4 masked event no request", {12'b0, int_req, xfer_req}, 16'h0);
        repeat (3) @(negedge clk);
        rd(3'd0, d); chk("R4 pending holds", d, 16'h0020);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        clean();
        fire(17'h000FF, 8'h0, 4'h0, 17'h0);
        wr(3'd0, 16'h000F);
        rd(3'd0, d); chk("R5 clear ones", d, 16'h00F0);
        wr(3'd0, 16'h0000);
        rd(3'd0, d); chk("R5 zeros keep", d, 16'h00F0);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 16'h0030; bus_we = 1; ev_cap = 17'h00010;
        @(negedge clk);
        bus_we = 0; ev_cap = '0;
        rd(3'd0, d); chk("R5 set wins over clear", d, 16'h00D0);
    endtask

    task automatic t_route();
        clean();
        fire(17'h00020, 8'h0, 4'h0, 17'h0);
        wr(3'd6, 16'h0001);
        chk("R6 masked with enable", {12'b0, int_req, xfer_req}, 16'h0);
        wr(3'd1, 16'h0020);
        chk("R6 group0 interrupt", {12'b0, int_req, xfer_req}, 16'b0100);
        wr(3'd6, 16'h0000);
        chk("R6 no enable no request", {12'b0, int_req, xfer_req}, 16'h0);
        wr(3'd1, 16'h0010);
        wr(3'd6, 16'h0001);
        chk("R6 mask on other bit", {12'b0, int_req, xfer_req}, 16'h0);
        clean();
        fire(17'h10000, 8'h0, 4'h0, 17'h0);
        wr(3'd3, 16'h8000);
        wr(3'd6, 16'h0008);
        chk("R6 group1 transfer", {12'b0, int_req, xfer_req}, 16'b0010);
    endtask

    task automatic t_both();
        clean();
        fire(17'h00001, 8'h0, 4'h0, 17'h0);
        wr(3'd1, 16'h0001);
        wr(3'd6, 16'h0003);
        chk("R7 transfer wins", {12'b0, int_req, xfer_req}, 16'b0001);
    endtask

    task automatic t_spare();
        logic [15:0] d;
        clean();
        fire(17'h10001, 8'h0, 4'h0, 17'h0);
        wr(3'd1, 16'hFFFF); wr(3'd3, 16'hFFFF);
        wr(3'd6, 16'h00F0);
        rd(3'd6, d); chk("R10 spare bits read back", d, 16'h00F0);
        chk("R10 spare bits no effect", {12'b0, int_req, xfer_req}, 16'h0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        clean();
        fire(17'h10081, 8'h0, 4'h0, 17'h0);
        wr(3'd1, 16'h1234);
        wr(3'd3, 16'hFFFF);
        rd(3'd0, d); chk("R11 group0 pend kept", d, 16'h0081);
        rd(3'd2, d); chk("R11 group1 pend kept", d, 16'h8000);
        rd(3'd1, d); chk("R11 mask read back", d, 16'h1234);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_grp0();
        t_grp1();
        t_shared();
        t_poll();
        t_w1c();
        t_route();
        t_both();
        t_spare();
        t_mask();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule